// File: doc/BRIEF.md
# Synchronizable Integer Clock Divider

This block divides a sample clock by a programmable whole-number ratio between 1 and 8. All of its logic runs in the input clock domain. It provides two outputs for the divided clock: a level output `div_clk_o` and a one-cycle enable `div_ce_o`. The enable marks the first input cycle of each divided period. Any ratio above 1 forces the duty-cycle stabilizer enable `stab_en_o` high, whatever the user setting of that bit.

An external alignment input, `sync_in`, may be asynchronous. It passes through a flop synchronizer and an edge detector, so each rising edge counts as one alignment event. An accepted event returns the divide counter to phase zero, which lets several dividers start their periods on the same input cycle. A control word sets how events are treated. They can be ignored, accepted every time, or accepted only once after each write of the control word. The one-cycle output `sync_hit_o` marks the cycle in which a realigned period begins.

Top module: `sample_clk_divider`

## Requirements
- R1: The ratio field of the control word is bits [5:3] and holds the ratio minus one, so codes 0 to 7 give ratios 1 to 8. With ratio N, `div_ce_o` is high for exactly one input cycle in every N cycles, and it stays high on every cycle when N is 1.
- R2: In each divided period, `div_clk_o` is high for the first (N+1)/2 cycles, counting from the cycle in which `div_ce_o` is high, and low for the rest. With N equal to 1 it stays high.
- R3: `stab_en_o` equals control bit 0 (the user stabilizer enable) OR'd with "ratio field is not zero". It takes the new value in the cycle after the write edge.
- R4: `sync_in` goes through two flops and then an edge detector. A rising edge that sets up before clock edge k, and is accepted, gives phase zero (`div_ce_o` high) and `sync_hit_o` high in the cycle after edge k+2. Holding `sync_in` high for several cycles counts as one event.
- R5: When control bit 1 (alignment enable) is clear, alignment events are ignored. `sync_hit_o` stays low and the counter phase does not change.
- R6: When bit 1 is set and bit 2 (once-only) is clear, every alignment event is accepted.
- R7: When bits 1 and 2 are both set, only the first event after a control write is accepted. Later events are ignored until the next write, and any write re-arms acceptance.
- R8: `sync_hit_o` is high for exactly one cycle for each accepted event. That cycle is the first cycle of the realigned period.
- R9: A change of ratio takes effect at the next counter wrap or the next accepted event, whichever comes first. The period that is running finishes at the old ratio, so no shortened period appears.
- R10: After synchronous reset, the control word is all zeros (ratio 1, alignment off, stabilizer bit off) and the once-only latch is disarmed. `div_ce_o` and `div_clk_o` are high, and `stab_en_o` and `sync_hit_o` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input sample clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Control word write strobe |
| cfg_wdata | input | 6 | Control word: [5:3] ratio-1, [2] once-only, [1] alignment enable, [0] user stabilizer enable |
| sync_in | input | 1 | Alignment input, may be asynchronous |
| div_clk_o | output | 1 | Divided clock level |
| div_ce_o | output | 1 | One-cycle enable at the start of each divided period |
| stab_en_o | output | 1 | Duty-cycle stabilizer enable |
| sync_hit_o | output | 1 | Pulses in the first cycle of a period realigned by an accepted event |

## Verification
A control write is visible in the cycle after its write edge, and `stab_en_o` is checked in that cycle. A rising edge of `sync_in` that is driven before edge k shows up as the realigned phase-zero cycle after edge k+2. The driver computes that cycle number when it raises `sync_in` and queues expected output values for every cycle of the following two periods. For a ratio change, the driver places the new period at the first wrap after the write and checks the remaining cycles of the old period cycle by cycle. The monitor compares values only at the falling edge of the exact cycle recorded with each queued item, and it reports any item whose cycle has already passed.

// File: rtl/clkdiv_pkg.sv
// Shared types for the synchronizable clock divider.
// Assumes the ratio is coded as value minus one in RATIO_W bits.
package clkdiv_pkg;
    localparam int RATIO_W = 3;
    localparam int CTRL_W  = RATIO_W + 3;

    // Control word layout, MSB first: ratio-1, once-only, align enable, user stabilizer.
    typedef struct packed {
        logic [RATIO_W-1:0] ratio_m1;
        logic               first_only;
        logic               sync_en;
        logic               stab_user;
    } div_ctrl_t;
endpackage

// File: rtl/clkdiv_sync_edge.sv
// Synchronizes an asynchronous alignment input and flags its rising edges.
// Assumes STAGES >= 1; output is a one-cycle pulse per rising edge.
module clkdiv_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise_o
);
    localparam int PIPE_W = STAGES + 1;

    logic [PIPE_W-1:0] pipe_q;

    // Shift the input through the synchronizer plus one history flop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pipe_q <= '0;
        end else begin
            pipe_q <= {pipe_q[PIPE_W-2:0], async_in};
        end
    end

    // Rising edge: newest synchronized sample high, previous one low.
    assign rise_o = pipe_q[STAGES-1] & ~pipe_q[STAGES];
endmodule

// File: rtl/clkdiv_ctrl.sv
// Holds the control word, the once-only arming latch and the accept decision.
// Assumes a write and an event in the same cycle leave the latch armed.
module clkdiv_ctrl
    import clkdiv_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      wr_en,
    input  div_ctrl_t wr_data,
    input  logic      sync_rise,
    output div_ctrl_t ctrl_o,
    output logic      accept_o,
    output logic      armed_o,
    output logic      stab_en_o
);
    div_ctrl_t ctrl_q;
    logic      armed_q;

    // Control word register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (wr_en) begin
            ctrl_q <= wr_data;
        end
    end

    // Once-only latch: armed by any write, cleared by an accepted event.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed_q <= 1'b0;
        end else if (wr_en) begin
            armed_q <= 1'b1;
        end else if (accept_o) begin
            armed_q <= 1'b0;
        end
    end

    // Accept decision and stabilizer forcing.
    always_comb begin
        accept_o  = sync_rise & ctrl_q.sync_en & (~ctrl_q.first_only | armed_q);
        stab_en_o = ctrl_q.stab_user | (ctrl_q.ratio_m1 != '0);
    end

    assign ctrl_o  = ctrl_q;
    assign armed_o = armed_q;
endmodule

// File: rtl/clkdiv_phase_ctr.sv
// Divide counter with a ratio that is loaded only at a wrap or a restart.
// Assumes ratio_m1_i holds the divide ratio minus one.
module clkdiv_phase_ctr #(
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] ratio_m1_i,
    input  logic             restart_i,
    output logic             ce_o,
    output logic             dclk_o,
    output logic             hit_o,
    output logic [CNT_W-1:0] ratio_act_o
);
    localparam int HW = CNT_W + 1;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] act_q;
    logic             hit_q;
    logic             wrap;
    logic [HW-1:0]    hi_len;

    assign wrap = (cnt_q == act_q);

    // Count the phase; reload the active ratio at a wrap or a restart.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            act_q <= '0;
        end else if (restart_i || wrap) begin
            cnt_q <= '0;
            act_q <= ratio_m1_i;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Register the restart so the pulse lines up with phase zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hit_q <= 1'b0;
        end else begin
            hit_q <= restart_i;
        end
    end

    // High time is ceil(N/2) with N = act_q + 1.
    always_comb begin
        hi_len = (HW'(act_q) + HW'(2)) >> 1;
        dclk_o = HW'(cnt_q) < hi_len;
        ce_o   = (cnt_q == '0);
    end

    assign hit_o       = hit_q;
    assign ratio_act_o = act_q;
endmodule

// File: rtl/sample_clk_divider.sv
// Top: integer sample clock divider with alignment input and stabilizer forcing.
// Assumes all logic runs on clk; sync_in may be asynchronous.
module sample_clk_divider #(
    parameter int SYNC_STAGES = 2
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         cfg_we,
    input  logic [clkdiv_pkg::CTRL_W-1:0] cfg_wdata,
    input  logic                         sync_in,
    output logic                         div_clk_o,
    output logic                         div_ce_o,
    output logic                         stab_en_o,
    output logic                         sync_hit_o
);
    import clkdiv_pkg::*;

    div_ctrl_t          ctrl_w;
    logic               rise_w;
    logic               accept_w;
    logic               armed_w;
    logic [RATIO_W-1:0] ratio_act_w;

    clkdiv_sync_edge #(.STAGES(SYNC_STAGES)) u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (sync_in),
        .rise_o   (rise_w)
    );

    clkdiv_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (cfg_we),
        .wr_data   (div_ctrl_t'(cfg_wdata)),
        .sync_rise (rise_w),
        .ctrl_o    (ctrl_w),
        .accept_o  (accept_w),
        .armed_o   (armed_w),
        .stab_en_o (stab_en_o)
    );

    clkdiv_phase_ctr #(.CNT_W(RATIO_W)) u_ctr (
        .clk         (clk),
        .rst_n       (rst_n),
        .ratio_m1_i  (ctrl_w.ratio_m1),
        .restart_i   (accept_w),
        .ce_o        (div_ce_o),
        .dclk_o      (div_clk_o),
        .hit_o       (sync_hit_o),
        .ratio_act_o (ratio_act_w)
    );
endmodule

// File: rtl/clkdiv_checks.sv
// Property checker for sample_clk_divider, attached by bind below.
module clkdiv_checks #(
    parameter int RW = 3,
    parameter int CW = 6
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cfg_we,
    input logic [CW-1:0] cfg_wdata,
    input logic          div_clk_o,
    input logic          div_ce_o,
    input logic          stab_en_o,
    input logic          sync_hit_o,
    input logic          sync_en,
    input logic          first_only,
    input logic          accept,
    input logic          armed,
    input logic [RW-1:0] ratio_act
);
    // R8: a realigned period starts at phase zero.
    assert_hit_phase_R8: assert property (@(posedge clk) disable iff (!rst_n)
        sync_hit_o |-> div_ce_o);

    // R4: one edge yields one event, never on back-to-back cycles.
    assert_hit_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        sync_hit_o |=> !sync_hit_o);

    // R3: a nonzero ratio write forces the stabilizer on.
    assert_stab_forced_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(cfg_we) && ($past(cfg_wdata[CW-1:3]) != '0)) |-> stab_en_o);

    // R5: with alignment disabled no event is accepted.
    assert_sync_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !sync_en |=> !sync_hit_o);

    // R1: for ratios above 1 the enable never repeats without a restart.
    assert_ce_gap_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (div_ce_o && (ratio_act != '0) && !accept) |=> !div_ce_o);

    // R2: the divided clock is high at the start of every period.
    assert_ce_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
        div_ce_o |-> div_clk_o);

    // R7: an accepted once-only event leaves the latch disarmed.
    assert_oneshot_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_hit_o && first_only && !$past(cfg_we)) |-> !armed);
endmodule

bind sample_clk_divider clkdiv_checks #(
    .RW (clkdiv_pkg::RATIO_W),
    .CW (clkdiv_pkg::CTRL_W)
) u_checks (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_we     (cfg_we),
    .cfg_wdata  (cfg_wdata),
    .div_clk_o  (div_clk_o),
    .div_ce_o   (div_ce_o),
    .stab_en_o  (stab_en_o),
    .sync_hit_o (sync_hit_o),
    .sync_en    (ctrl_w.sync_en),
    .first_only (ctrl_w.first_only),
    .accept     (accept_w),
    .armed      (armed_w),
    .ratio_act  (ratio_act_w)
);

// File: tb/sample_clk_divider_test.sv
// Scoreboard bench: driver tasks queue expected per-cycle outputs, monitor compares.
module sample_clk_divider_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_we = 1'b0;
    logic [5:0] cfg_wdata = '0;
    logic       sync_in = 1'b0;
    logic       div_clk_o, div_ce_o, stab_en_o, sync_hit_o;

    sample_clk_divider uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_we     (cfg_we),
        .cfg_wdata  (cfg_wdata),
        .sync_in    (sync_in),
        .div_clk_o  (div_clk_o),
        .div_ce_o   (div_ce_o),
        .stab_en_o  (stab_en_o),
        .sync_hit_o (sync_hit_o)
    );

    always #10 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    typedef struct {
        int    at;
        bit    phase;
        bit    ce;
        bit    dclk;
        bit    hit;
        bit    stab;
        string req;
    } exp_t;

    exp_t  q[$];
    int    checks = 0;
    int    fails = 0;
    bit    cur_stab = 1'b0;

    task automatic chk(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s cycle %0d actual=%0d expected=%0d", req, what, cyc, act, exp);
        end
    endtask

    // Monitor: compare the queue head at the falling edge of its cycle.
    always @(negedge clk) begin
        exp_t e;
        while (q.size() > 0 && q[0].at < cyc) begin
            e = q.pop_front();
            checks++;
            fails++;
            $display("FAIL %s item for cycle %0d missed actual=none expected=sampled", e.req, e.at);
        end
        while (q.size() > 0 && q[0].at == cyc) begin
            e = q.pop_front();
            if (e.phase) begin
                chk(e.req, "div_ce_o", div_ce_o, e.ce);
                chk(e.req, "div_clk_o", div_clk_o, e.dclk);
                chk(e.req, "sync_hit_o", sync_hit_o, e.hit);
            end
            chk(e.req, "stab_en_o", stab_en_o, e.stab);
        end
    end

    // Queue expected outputs for cycles from..to, phase zero at base, ratio n.
    task automatic push_win(int from, int to, int base, int n, int hit_at, string req);
        for (int c = from; c <= to; c++) begin
            exp_t e;
            int   j;
            j      = (c - base) % n;
            e.at   = c;
            e.phase = 1'b1;
            e.ce   = (j == 0);
            e.dclk = (j < (n + 1) / 2);
            e.hit  = (c == hit_at);
            e.stab = cur_stab;
            e.req  = req;
            q.push_back(e);
        end
    endtask

    task automatic push_stab(int at, string req);
        exp_t e;
        e.at = at; e.phase = 1'b0; e.ce = 1'b0; e.dclk = 1'b0; e.hit = 1'b0;
        e.stab = cur_stab; e.req = req;
        q.push_back(e);
    endtask

    // Control write; returns in the first cycle the new word is visible.
    task automatic write_cfg(int n, bit sen, bit first, bit stab);
        cfg_wdata = {3'(n - 1), first, sen, stab};
        cfg_we    = 1'b1;
        cur_stab  = stab | (n != 1);
        @(negedge clk);
        cfg_we    = 1'b0;
    endtask

    task automatic sync_pulse(int hold);
        sync_in = 1'b1;
        repeat (hold) @(negedge clk);
        sync_in = 1'b0;
    endtask

    task automatic wait_to(int c);
        while (cyc < c) @(negedge clk);
    endtask

    initial begin
        int a;
        int b;
        int w;
        int z;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R10: reset state, ratio 1, no stabilizer, no hit.
        push_win(cyc + 1, cyc + 4, cyc + 1, 1, -1, "R10");
        wait_to(cyc + 5);

        // R1 R2 R4 R6 R8: every ratio, realigned by a held alignment pulse.
        for (int n = 1; n <= 8; n++) begin
            write_cfg(n, 1'b1, 1'b0, 1'b0);
            a = cyc + 3;
            push_win(a, a + 2 * n - 1, a, n, a, "R1 R2 R4 R6 R8");
            sync_pulse(3);
            wait_to(a + 2 * n);
        end

        // R3: stabilizer output against user bit and ratio.
        write_cfg(1, 1'b0, 1'b0, 1'b0);
        push_stab(cyc + 1, "R3");
        wait_to(cyc + 2);
        write_cfg(1, 1'b0, 1'b0, 1'b1);
        push_stab(cyc + 1, "R3");
        wait_to(cyc + 2);
        write_cfg(5, 1'b0, 1'b0, 1'b0);
        push_stab(cyc + 1, "R3");
        wait_to(cyc + 2);

        // R5: alignment disabled, phase must continue undisturbed.
        write_cfg(4, 1'b1, 1'b0, 1'b0);
        a = cyc + 3;
        push_win(a, a + 3, a, 4, a, "R6");
        sync_pulse(2);
        wait_to(a + 5);
        write_cfg(4, 1'b0, 1'b0, 1'b0);
        b = cyc + 3;
        push_win(cyc + 1, b + 7, a, 4, -1, "R5");
        sync_pulse(3);
        wait_to(b + 8);

        // R7: once-only mode, second event ignored, write re-arms.
        write_cfg(4, 1'b1, 1'b1, 1'b0);
        @(negedge clk);
        a = cyc + 3;
        push_win(a, a + 5, a, 4, a, "R7");
        sync_pulse(3);
        wait_to(a + 6);
        b = cyc + 3;
        push_win(b - 1, b + 4, a, 4, -1, "R7");
        sync_pulse(3);
        wait_to(b + 5);
        write_cfg(4, 1'b1, 1'b1, 1'b0);
        a = cyc + 3;
        push_win(a, a + 5, a, 4, a, "R7");
        sync_pulse(3);
        wait_to(a + 6);

        // R9: ratio change mid-period waits for the wrap.
        write_cfg(4, 1'b1, 1'b0, 1'b0);
        a = cyc + 3;
        push_win(a, a + 3, a, 4, a, "R9");
        sync_pulse(2);
        wait_to(a + 4);
        write_cfg(3, 1'b0, 1'b0, 1'b0);
        w = cyc;
        z = a + 8;
        push_win(w + 1, z - 1, a, 4, -1, "R9");
        push_win(z, z + 8, z, 3, -1, "R9");
        wait_to(z + 9);

        @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        #4000000;
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule